// File: doc/BRIEF.md
# Four-Byte Page Programming Sequencer

This block drives the control pins of a one-time-programmable byte-wide memory through an adaptive page-programming run. The image is written four bytes at a time. The sequencer stages each byte of a page into the memory's page buffer with an output-enable strobe while chip enable stays inactive. It then fires one shared programming pulse and reads all four bytes back. Pulse and verify repeat until the page matches or the attempt limit is reached. A passing page gets an extra overprogram pulse whose length scales with the number of pulses that page needed. The sequencer then moves to the next page.

After the last page it drops the high-voltage supply request and reads every address back against the image. The image byte for the current address comes in on `img_data_i`, looked up from `addr_o`. Bus data is split into `dq_i` and `dq_o`, and `dq_oe_o` marks when the sequencer drives. Every interval is a parameter in clock cycles: setup and hold gap, latch strobe width, program pulse width, overprogram unit and read access.

Top module: `otp_pgseq`

## Requirements
- R1: After reset and whenever idle, `ce_n_o`, `oe_n_o` and `pgm_n_o` are high and `dq_oe_o`, `vpp_o`, `busy_o`, `done_o` and `fail_o` are low.
- R2: Each byte of a page is latched as follows. `oe_n_o` goes low for exactly T_LW cycles. During the strobe `ce_n_o` and `pgm_n_o` stay high, `dq_oe_o` and `vpp_o` are high, and `dq_o` carries the image byte of `addr_o`. Addresses are latched in ascending order from 0, and each address is latched once. The page is bits [AW-1:2] of `addr_o`; the byte within it is bits [1:0].
- R3: A program pulse holds `pgm_n_o` low with `ce_n_o` and `oe_n_o` high, `dq_oe_o` low and `vpp_o` high. A normal pulse lasts T_PW cycles. Each page receives one normal pulse per attempt.
- R4: After each normal pulse the four bytes of the page are read in ascending order, with `ce_n_o` and `oe_n_o` both low. On any mismatch the page is pulsed again. When all four match after n pulses, an overprogram pulse of n*T_OPW cycles follows, and then the next page is latched.
- R5: Suppose MAX_TRY pulses have been applied and the page still mismatches. Then the run ends with `fail_o` high and `fail_addr_o` set to the lowest address in that page that mismatched at the last verify. No overprogram pulse is given, and `vpp_o` and `busy_o` fall.
- R6: After the last page's overprogram pulse, `vpp_o` falls and every address is read once in ascending order. If all bytes match, `done_o` rises. Otherwise `fail_o` rises and `fail_addr_o` holds the first mismatching address.
- R7: `start_i` has no effect while `busy_o` is high. `done_o` and `fail_o` hold their value until the next start.
- R8: Asserting `rst_ni` low in mid-run returns all outputs to the R1 state at once, and a later start runs a full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (accepted only when idle) |
| img_data_i | input | DW | Image byte for the current `addr_o` |
| dq_i | input | DW | Data read from the memory |
| addr_o | output | AW | Memory address ({page, byte}) |
| dq_o | output | DW | Data driven to the memory |
| dq_oe_o | output | 1 | Sequencer drives the data bus |
| ce_n_o | output | 1 | Chip enable, active low |
| oe_n_o | output | 1 | Output enable / latch strobe, active low |
| pgm_n_o | output | 1 | Program pulse, active low |
| vpp_o | output | 1 | Request for the programming supply level |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished with a matching image |
| fail_o | output | 1 | Run aborted or read-back mismatch |
| fail_addr_o | output | AW | Address of the reported mismatch |

## Verification
The strobes change on the clock edge after the state that owns them is entered. The bench samples every pin at the falling edge and measures strobe widths and pulse counts in whole cycles. A read sample is taken on the last cycle of its T_RD window. The pass or fail decision follows on the single gap cycle after it, so `done_o`, `fail_o` and `fail_addr_o` are due on the same edge where `busy_o` falls. The bench therefore reads them at the first falling edge with `busy_o` low. The expected pulse totals, low-cycle totals, latch and read counts, and failing addresses all come from a per-address count of pulses needed. The bench computes them from the table before each run.

// File: rtl/otp_pgseq_pkg.sv
package otp_pgseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LSU, S_LPW, S_LHD, S_PSU, S_PPW, S_PHD, S_VRD, S_VGP, S_RSU
  } st_e;
endpackage

// File: rtl/otp_pgseq_timer.sv
module otp_pgseq_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (ld_i)          cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/otp_pgseq_vchk.sv
module otp_pgseq_vchk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          smp_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rd_i,
  input  logic [DW-1:0] exp_i,
  output logic          bad_o,
  output logic [AW-1:0] first_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_o   <= 1'b0;
      first_o <= '0;
    end else if (clr_i) begin
      bad_o   <= 1'b0;
    end else if (smp_i && (rd_i != exp_i) && !bad_o) begin
      // keep only the lowest mismatching address of the group
      bad_o   <= 1'b1;
      first_o <= addr_i;
    end
  end
endmodule

// File: rtl/otp_pgseq.sv
module otp_pgseq
  import otp_pgseq_pkg::*;
#(
  parameter int N_ADDR  = 16,
  parameter int DW      = 8,
  parameter int T_SU    = 2,
  parameter int T_LW    = 3,
  parameter int T_PW    = 4,
  parameter int T_OPW   = 2,
  parameter int T_RD    = 2,
  parameter int MAX_TRY = 25,
  parameter int TW      = 16,
  localparam int AW     = $clog2(N_ADDR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] img_data_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic          pgm_n_o,
  output logic          vpp_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);
  localparam int PGW = AW - 2;
  localparam int NW  = $clog2(MAX_TRY + 1);
  localparam logic [PGW-1:0] LAST_PG = PGW'(N_ADDR / 4 - 1);
  localparam logic [AW-1:0]  LAST_A  = AW'(N_ADDR - 1);

  st_e            st_q, st_d;
  logic [PGW-1:0] pg_q, pg_d;
  logic [1:0]     bi_q, bi_d;
  logic [NW-1:0]  n_q, n_d;
  logic           opw_q, opw_d, rb_q, rb_d, vpp_q, vpp_d;
  logic           done_q, done_d, fail_q, fail_d;
  logic [AW-1:0]  faddr_q, faddr_d, nxt_a;
  logic           ld, tz, v_clr, v_smp, v_bad;
  logic [TW-1:0]  ld_val, opw_len;
  logic [AW-1:0]  v_first;

  otp_pgseq_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .ld_i(ld), .val_i(ld_val), .zero_o(tz)
  );

  otp_pgseq_vchk #(.AW(AW), .DW(DW)) u_vchk (
    .clk_i, .rst_ni, .clr_i(v_clr), .smp_i(v_smp), .addr_i(addr_o),
    .rd_i(dq_i), .exp_i(img_data_i), .bad_o(v_bad), .first_o(v_first)
  );

  assign addr_o  = {pg_q, bi_q};
  assign nxt_a   = addr_o + 1'b1;
  assign opw_len = TW'(n_q) * TW'(T_OPW) - 1'b1;

  always_comb begin
    st_d = st_q; pg_d = pg_q; bi_d = bi_q; n_d = n_q; opw_d = opw_q;
    rb_d = rb_q; vpp_d = vpp_q; done_d = done_q; fail_d = fail_q;
    faddr_d = faddr_q; ld = 1'b0; ld_val = '0; v_clr = 1'b0; v_smp = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d = S_LSU; ld = 1'b1; ld_val = TW'(T_SU - 1);
        pg_d = '0; bi_d = '0; n_d = '0; opw_d = 1'b0; rb_d = 1'b0;
        vpp_d = 1'b1; done_d = 1'b0; fail_d = 1'b0; faddr_d = '0;
      end
      S_LSU: if (tz) begin st_d = S_LPW; ld = 1'b1; ld_val = TW'(T_LW - 1); end
      S_LPW: if (tz) begin st_d = S_LHD; ld = 1'b1; ld_val = TW'(T_SU - 1); end
      S_LHD: if (tz) begin
        ld = 1'b1; ld_val = TW'(T_SU - 1);
        if (bi_q == 2'd3) begin bi_d = '0; n_d = '0; st_d = S_PSU; end
        else begin bi_d = bi_q + 1'b1; st_d = S_LSU; end
      end
      S_PSU: if (tz) begin
        st_d = S_PPW; ld = 1'b1;
        if (opw_q) ld_val = opw_len;
        else begin ld_val = TW'(T_PW - 1); n_d = n_q + 1'b1; end
      end
      S_PPW: if (tz) begin st_d = S_PHD; ld = 1'b1; ld_val = TW'(T_SU - 1); end
      S_PHD: if (tz) begin
        ld = 1'b1;
        if (opw_q) begin
          opw_d = 1'b0; ld_val = TW'(T_SU - 1);
          if (pg_q == LAST_PG) begin st_d = S_RSU; vpp_d = 1'b0; end
          else begin pg_d = pg_q + 1'b1; bi_d = '0; st_d = S_LSU; end
        end else begin
          st_d = S_VRD; bi_d = '0; v_clr = 1'b1; ld_val = TW'(T_RD - 1);
        end
      end
      S_VRD: if (tz) begin v_smp = 1'b1; st_d = S_VGP; ld = 1'b1; ld_val = '0; end
      S_VGP: if (tz) begin
        if (rb_q) begin
          if (addr_o == LAST_A) begin
            st_d = S_IDLE;
            if (v_bad) begin fail_d = 1'b1; faddr_d = v_first; end
            else done_d = 1'b1;
          end else begin
            pg_d = nxt_a[AW-1:2]; bi_d = nxt_a[1:0];
            st_d = S_VRD; ld = 1'b1; ld_val = TW'(T_RD - 1);
          end
        end else if (bi_q != 2'd3) begin
          bi_d = bi_q + 1'b1; st_d = S_VRD; ld = 1'b1; ld_val = TW'(T_RD - 1);
        end else begin
          bi_d = '0;
          if (v_bad && (n_q == NW'(MAX_TRY))) begin
            st_d = S_IDLE; fail_d = 1'b1; faddr_d = v_first; vpp_d = 1'b0;
          end else begin
            opw_d = !v_bad; st_d = S_PSU; ld = 1'b1; ld_val = TW'(T_SU - 1);
          end
        end
      end
      S_RSU: if (tz) begin
        st_d = S_VRD; rb_d = 1'b1; pg_d = '0; bi_d = '0; v_clr = 1'b1;
        ld = 1'b1; ld_val = TW'(T_RD - 1);
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; pg_q <= '0; bi_q <= '0; n_q <= '0; opw_q <= 1'b0;
      rb_q <= 1'b0; vpp_q <= 1'b0; done_q <= 1'b0; fail_q <= 1'b0;
      faddr_q <= '0;
    end else begin
      st_q <= st_d; pg_q <= pg_d; bi_q <= bi_d; n_q <= n_d; opw_q <= opw_d;
      rb_q <= rb_d; vpp_q <= vpp_d; done_q <= done_d; fail_q <= fail_d;
      faddr_q <= faddr_d;
    end
  end

  assign dq_o        = img_data_i;
  assign dq_oe_o     = (st_q == S_LSU) || (st_q == S_LPW) || (st_q == S_LHD);
  assign oe_n_o      = !((st_q == S_LPW) || (st_q == S_VRD));
  assign ce_n_o      = !((st_q == S_VRD) || (st_q == S_VGP));
  assign pgm_n_o     = (st_q != S_PPW);
  assign vpp_o       = vpp_q;
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign fail_addr_o = faddr_q;
endmodule

// File: rtl/otp_pgseq_chk.sv
module otp_pgseq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dq_oe_o,
  input logic ce_n_o,
  input logic oe_n_o,
  input logic pgm_n_o,
  input logic vpp_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_n_o && oe_n_o && pgm_n_o && !dq_oe_o));
  // R2
  latch_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_n_o && !oe_n_o) |-> (dq_oe_o && pgm_n_o && vpp_o));
  // R3
  prog_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgm_n_o |-> (vpp_o && ce_n_o && oe_n_o && !dq_oe_o));
  // R4
  verify_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_o && !oe_n_o) |-> (!dq_oe_o && pgm_n_o));
  // R5
  end_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fail_o) || $rose(done_o)) |-> (!busy_o && !vpp_o));
  // R6
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
endmodule

bind otp_pgseq otp_pgseq_chk u_chk (.*);

// File: tb/otp_pgseq_tb_top.sv
module otp_pgseq_tb_top;
  localparam int N = 16, TSU = 2, TLW = 3, TPW = 4, TOPW = 2, TRD = 2, MAXT = 25, AW = 4;

  typedef struct packed {
    logic [5:0] base; logic [3:0] wa; logic [5:0] wn;
    logic [3:0] wb; logic [5:0] wbn; logic dec; logic [3:0] da;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{6'd1, 4'd0,  6'd1,  4'd0, 6'd1, 1'b0, 4'd0},   // all pages first try
    '{6'd2, 4'd6,  6'd5,  4'd6, 6'd5, 1'b0, 4'd0},   // slow page 1
    '{6'd1, 4'd13, 6'd25, 4'd0, 6'd1, 1'b0, 4'd0},   // pass on the last allowed pulse
    '{6'd1, 4'd9,  6'd26, 4'd0, 6'd1, 1'b0, 4'd0},   // one over the limit
    '{6'd1, 4'd11, 6'd30, 4'd8, 6'd3, 1'b0, 4'd0},   // early mismatch clears later
    '{6'd3, 4'd0,  6'd1,  4'd0, 6'd1, 1'b1, 4'd5},   // read-back mismatch
    '{6'd1, 4'd0,  6'd1,  4'd0, 6'd1, 1'b1, 4'd15}   // read-back mismatch at last address
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni = 1'b0, start_i = 1'b0;
  logic [7:0] img_data, dq_in, dq_out;
  logic [AW-1:0] addr, fail_addr;
  logic dq_oe, ce_n, oe_n, pgm_n, vpp, busy, done, fail;

  otp_pgseq #(.N_ADDR(N), .DW(8), .T_SU(TSU), .T_LW(TLW), .T_PW(TPW),
              .T_OPW(TOPW), .T_RD(TRD), .MAX_TRY(MAXT), .TW(16)) dut_i (
    .clk_i(clk), .rst_ni, .start_i, .img_data_i(img_data), .dq_i(dq_in),
    .addr_o(addr), .dq_o(dq_out), .dq_oe_o(dq_oe), .ce_n_o(ce_n), .oe_n_o(oe_n),
    .pgm_n_o(pgm_n), .vpp_o(vpp), .busy_o(busy), .done_o(done), .fail_o(fail),
    .fail_addr_o(fail_addr)
  );

  logic [7:0] mem [N];
  int need [N];
  int pcnt [N];
  logic [7:0] pbuf [4];
  logic dec_en = 1'b0;
  int dec_a = 0;

  function automatic logic [7:0] img(int a);
    return 8'(5 + 37 * a);
  endfunction

  assign img_data = img(int'(addr));
  assign dq_in = (!ce_n && !oe_n) ? mem[addr] : 8'h00;

  int n_cmp = 0, n_mis = 0;
  bit finished = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and pin monitor, sampled on the falling edge
  logic prev_oe = 1'b1, prev_pgm = 1'b1, prev_vpp = 1'b0;
  int oe_w, lat_cnt, lat_err, w_err, pgm_cnt, pgm_low, ver_cnt, ver_err, rb_cnt, rb_err;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (!oe_n) oe_w = prev_oe ? 1 : oe_w + 1;
      if (prev_oe && !oe_n) begin
        if (ce_n) begin
          if (int'(addr) != lat_cnt || !dq_oe || dq_out != img(int'(addr))) lat_err++;
          pbuf[addr[1:0]] = dq_out;
          lat_cnt++;
        end else if (vpp) begin
          if (int'(addr[1:0]) != ver_cnt % 4) ver_err++;
          ver_cnt++;
        end else begin
          if (int'(addr) != rb_cnt) rb_err++;
          rb_cnt++;
        end
      end
      if (!prev_oe && oe_n && ce_n && oe_w != TLW) w_err++;
      if (!pgm_n) pgm_low++;
      if (prev_pgm && !pgm_n) pgm_cnt++;
      if (!prev_pgm && pgm_n) begin
        for (int k = 0; k < 4; k++) begin
          int a;
          a = (int'(addr) / 4) * 4 + k;
          pcnt[a]++;
          if (pcnt[a] >= need[a]) mem[a] = mem[a] & pbuf[k];
        end
      end
      if (prev_vpp && !vpp && dec_en) mem[dec_a] = mem[dec_a] ^ 8'h01;
    end
    prev_oe = oe_n; prev_pgm = pgm_n; prev_vpp = vpp;
  end

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 30000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 30000) chk("watchdog", 0, 1);
  endtask

  task automatic run_case(vec_t v, bit extra);
    int ep = 0, el = 0, elat = 0, ever = 0, pf = 0, pfa = 0, erb, rbf, efa;
    for (int a = 0; a < N; a++) begin
      mem[a] = 8'hFF; pcnt[a] = 0; need[a] = int'(v.base);
    end
    need[v.wa] = int'(v.wn);
    need[v.wb] = int'(v.wbn);
    dec_en = v.dec; dec_a = int'(v.da);
    lat_cnt = 0; lat_err = 0; w_err = 0; pgm_cnt = 0; pgm_low = 0;
    ver_cnt = 0; ver_err = 0; rb_cnt = 0; rb_err = 0;
    for (int p = 0; p < N / 4; p++) begin
      if (pf == 0) begin
        int m = 1;
        for (int k = 0; k < 4; k++) if (need[p*4+k] > m) m = need[p*4+k];
        elat += 4;
        if (m > MAXT) begin
          pf = 1; ep += MAXT; el += MAXT * TPW; ever += 4 * MAXT;
          pfa = -1;
          for (int k = 3; k >= 0; k--) if (need[p*4+k] > MAXT) pfa = p * 4 + k;
        end else begin
          ep += m + 1; el += m * TPW + m * TOPW; ever += 4 * m;
        end
      end
    end
    erb = (pf != 0) ? 0 : N;
    rbf = (pf == 0 && v.dec) ? 1 : 0;
    efa = (pf != 0) ? pfa : int'(v.da);

    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (extra) begin
      repeat (60) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    wait_idle();

    chk("R5 fail_o", int'(fail), (pf != 0 || rbf != 0) ? 1 : 0);
    chk("R6 done_o", int'(done), (pf == 0 && rbf == 0) ? 1 : 0);
    if (pf != 0 || rbf != 0) chk("R5/R6 fail_addr_o", int'(fail_addr), efa);
    chk("R3 pulse count", pgm_cnt, ep);
    chk("R4 pgm low cycles incl overprogram", pgm_low, el);
    chk("R2 latch count", lat_cnt, elat);
    chk("R2 latch order/data", lat_err, 0);
    chk("R2 strobe width", w_err, 0);
    chk("R4 verify reads", ver_cnt, ever);
    chk("R4 verify order", ver_err, 0);
    chk("R6 read-back count", rb_cnt, erb);
    chk("R6 read-back order", rb_err, 0);
    chk("R5 supply released", int'(vpp), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ce_n", int'(ce_n), 1);
    chk("R1 oe_n", int'(oe_n), 1);
    chk("R1 pgm_n", int'(pgm_n), 1);
    chk("R1 vpp/dq_oe", int'({vpp, dq_oe}), 0);
    chk("R1 busy/done/fail", int'({busy, done, fail}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 7; i++) run_case(VEC[i], 1'b0);

    // R7: start during a run changes nothing; outcome is held
    run_case(VEC[1], 1'b1);
    repeat (10) @(negedge clk);
    chk("R7 done held", int'(done), 1);
    chk("R7 still idle", int'(busy), 0);

    // R8: reset in mid-run
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (100) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R8 busy after reset", int'(busy), 0);
    chk("R8 strobes after reset", int'({ce_n, oe_n, pgm_n}), 7);
    chk("R8 vpp/dq_oe after reset", int'({vpp, dq_oe}), 0);
    chk("R8 done/fail after reset", int'({done, fail}), 0);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    run_case(VEC[0], 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end
endmodule